// File: doc/BRIEF.md
# PCM Highway Timeslot Port

This block connects one voice channel to a time-division multiplexed serial highway. It runs directly on the highway bit clock. A frame-sync input marks where each frame starts, and a bit-position counter tracks every bit period of the frame. The frame length is a parameter; a 2.048 MHz clock with an 8 kHz frame rate gives 256 bit periods per 125 µs frame.

In every frame the port does two things:
- It serialises one transmit sample onto the tri-state DTX line, most significant bit first, inside its own transmit timeslot.
- It deserialises one receive sample from DRX inside its own receive timeslot.

A sample is either an 8-bit companded byte or a 16-bit linear word. A 16-bit word fills two adjacent 8-bit slots. The transmit and receive slot positions are set independently, as bit counts from the first bit of the frame.

On the parallel side, the block takes a transmit sample once per frame and signals that moment with a frame tick. It returns each received sample with a one-cycle valid strobe. Two frame-sync shapes are accepted:
- a one-clock pulse in the period before bit 0;
- a level that is high while bit 0 is on the line.

The counter runs freely between syncs. A sync that does not fall on the expected frame boundary realigns the counter and raises a one-cycle frame-error pulse.

Top module: `pcmhw_port`

## Requirements
- R1: While `rst` is high at a rising `pclk` edge, all state clears. In the cycle after such an edge, `dtx` is high impedance and `rx_valid`, `frame_tick` and `frame_err` are 0.
- R2: A sync event marks where bit 0 of a frame falls.
  - Short format (`cfg_fs_long`=0): the event is `fsync` sampled high at a rising edge, and the bit period that begins at that edge is bit 0.
  - Long format (`cfg_fs_long`=1): the event is the first rising edge at which `fsync` is sampled high after being low, and the period that begins there is bit 1.
  - Between events, the bit position advances by one per clock and wraps after FRAME_BITS periods.
- R3: `dtx` is high impedance in every bit period outside the transmit slot. The transmit slot is the `cfg_tx_start` bit periods after bit 0, for 8 periods when `cfg_lin16`=0 or 16 periods when `cfg_lin16`=1.
- R4: Inside the transmit slot, `dtx` carries the captured sample most significant bit first: `tx_sample[7:0]` in 8-bit mode, `tx_sample[15:0]` in 16-bit mode. Each bit changes on the rising edge.
  - `tx_sample` is captured at the rising edge that starts bit 0.
  - Changing `tx_sample` later in the frame has no effect on that frame's transmission.
- R5: With `cfg_rel_late`=0, `dtx` goes high impedance at the falling edge in the middle of the last slot bit. With `cfg_rel_late`=1, it stays driven for the whole last bit and floats from the next rising edge.
- R6: DRX is sampled on falling edges inside the receive slot, which starts `cfg_rx_start` bit periods after bit 0 and has the same length as the transmit slot. The first bit sampled is the most significant.
  - `rx_valid` is high for exactly the one bit period that follows the last slot bit.
  - In that period, `rx_sample` holds the word, zero-extended to 16 bits in 8-bit mode.
- R7: The transmit and receive slot positions are independent. They may be equal, overlap or be far apart.
- R8: A sync event that does not land where the free-running count expects it asserts `frame_err` for one bit period. It realigns the counter per R2 and reloads the transmit sample, so `frame_tick` is also high in that period. The first sync event after reset realigns without an error.
- R9: From reset until the first sync event, `dtx` stays high impedance and `rx_valid` stays 0.
- R10: In steady framing, `frame_tick` is high for exactly one period per frame: the bit-0 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, short or long shape |
| drx | input | 1 | Serial receive data from the highway |
| dtx | output | 1 | Serial transmit data, tri-state |
| cfg_fs_long | input | 1 | 1 = long frame sync, 0 = short |
| cfg_lin16 | input | 1 | 1 = 16-bit linear sample, 0 = 8-bit companded |
| cfg_rel_late | input | 1 | 1 = float after the last bit, 0 = float mid last bit |
| cfg_tx_start | input | $clog2(FRAME_BITS) | First transmit bit position |
| cfg_rx_start | input | $clog2(FRAME_BITS) | First receive bit position |
| tx_sample | input | 16 | Sample to send in the next frame |
| rx_sample | output | 16 | Last received sample |
| rx_valid | output | 1 | One-period strobe for a new `rx_sample` |
| frame_tick | output | 1 | Transmit sample captured (bit-0 period) |
| frame_err | output | 1 | One-period pulse on a misplaced sync |

## Verification
Some properties are checked on every cycle:
- the output enable never rises before the first sync;
- the output enable only appears inside the transmit window;
- the receive strobe lasts one period and always lands just past the receive window;
- a frame error always comes with a sample reload.

Other behaviour only the bench's scenarios can show:
- the actual bit order on `dtx` and the contents of `rx_sample`;
- the mid-bit against end-of-bit release;
- how the short and long sync shapes shift bit 0;
- that a sample changed after the tick stays out of the current frame;
- realignment after a sync that arrives early.

// File: rtl/pcmhw_pkg.sv
package pcmhw_pkg;

    typedef enum logic {
        FS_SHORT = 1'b0,
        FS_LONG  = 1'b1
    } fs_fmt_e;

    typedef enum logic {
        SMP_COMP8 = 1'b0,
        SMP_LIN16 = 1'b1
    } smp_width_e;

    typedef enum logic {
        REL_MID_LSB   = 1'b0,
        REL_AFTER_LSB = 1'b1
    } rel_edge_e;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned BYTE_W   = 8;

    typedef struct packed {
        fs_fmt_e    fs_fmt;
        smp_width_e width;
        rel_edge_e  rel;
    } hw_cfg_t;

    // number of bit periods a sample occupies on the highway
    function automatic logic [4:0] slot_len(smp_width_e w);
        return (w == SMP_LIN16) ? 5'd16 : 5'd8;
    endfunction

    // bit index into the sample for a given offset inside the slot
    function automatic logic [3:0] bit_index(smp_width_e w, logic [3:0] off);
        return (w == SMP_LIN16) ? (4'd15 - off) : (4'd7 - off);
    endfunction

endpackage

// File: rtl/pcmhw_framer.sv
module pcmhw_framer
    import pcmhw_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 64,
    localparam int unsigned CW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fsync,
    input  fs_fmt_e       fs_fmt,
    output logic [CW-1:0] pos,
    output logic          locked,
    output logic          load,
    output logic          frame_tick,
    output logic          frame_err
);

    logic          fs_q;
    logic [CW-1:0] pos_q;
    logic [CW-1:0] pos_wrap;
    logic [CW-1:0] pos_ref;
    logic          fs_evt;
    logic          locked_q;
    logic          tick_q;
    logic          err_q;
    logic          load_w;

    assign pos_wrap = (pos_q == CW'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
    assign pos_ref  = (fs_fmt == FS_LONG) ? CW'(1) : '0;
    assign fs_evt   = (fs_fmt == FS_LONG) ? (fsync && !fs_q) : fsync;

    always_comb begin
        if (fs_evt) begin
            // short sync always marks bit 0; long sync reloads only on realignment
            load_w = !locked_q || (pos_wrap != pos_ref) || (fs_fmt == FS_SHORT);
        end else begin
            load_w = locked_q && (pos_wrap == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q     <= 1'b0;
            pos_q    <= '0;
            locked_q <= 1'b0;
            tick_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            fs_q   <= fsync;
            tick_q <= load_w;
            if (fs_evt) begin
                pos_q    <= pos_ref;
                locked_q <= 1'b1;
                err_q    <= locked_q && (pos_wrap != pos_ref);
            end else begin
                pos_q <= pos_wrap;
                err_q <= 1'b0;
            end
        end
    end

    assign pos        = pos_q;
    assign locked     = locked_q;
    assign load       = load_w;
    assign frame_tick = tick_q;
    assign frame_err  = err_q;

endmodule

// File: rtl/pcmhw_slot_win.sv
module pcmhw_slot_win
    import pcmhw_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] start,
    input  smp_width_e    width,
    output logic [CW-1:0] off,
    output logic          in_slot,
    output logic          is_last
);

    logic [CW-1:0] len;

    assign len     = CW'(slot_len(width));
    assign off     = pos - start;
    assign in_slot = (off < len);
    assign is_last = (off == (len - 1'b1));

endmodule

// File: rtl/pcmhw_tx.sv
module pcmhw_tx
    import pcmhw_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                locked,
    input  logic                in_slot,
    input  logic                is_last,
    input  logic [CW-1:0]       off,
    input  smp_width_e          width,
    input  rel_edge_e           rel,
    output logic                oe,
    output logic                bit_out
);

    logic [SAMPLE_W-1:0] hold_q;
    logic                cut_q;
    logic [3:0]          idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= tx_sample;
        end
    end

    // mid-bit marker: set at the falling edge inside the last slot bit
    always_ff @(negedge clk) begin
        if (rst) begin
            cut_q <= 1'b0;
        end else begin
            cut_q <= in_slot && is_last;
        end
    end

    assign idx     = bit_index(width, off[3:0]);
    assign bit_out = hold_q[idx];
    assign oe      = locked && in_slot &&
                     !((rel == REL_MID_LSB) && cut_q && is_last);

endmodule

// File: rtl/pcmhw_rx.sv
module pcmhw_rx
    import pcmhw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                drx,
    input  logic                locked,
    input  logic                in_slot,
    input  logic                is_last,
    input  smp_width_e          width,
    output logic [SAMPLE_W-1:0] data,
    output logic                valid
);

    logic [SAMPLE_W-1:0] sh_q;
    logic                last_n;
    logic [SAMPLE_W-1:0] data_q;
    logic                valid_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_n <= 1'b0;
        end else begin
            if (locked && in_slot) begin
                sh_q <= {sh_q[SAMPLE_W-2:0], drx};
            end
            last_n <= locked && in_slot && is_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= last_n;
            if (last_n) begin
                data_q <= (width == SMP_LIN16) ? sh_q
                                               : {{(SAMPLE_W-BYTE_W){1'b0}}, sh_q[BYTE_W-1:0]};
            end
        end
    end

    assign data  = data_q;
    assign valid = valid_q;

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R6

endmodule

// File: rtl/pcmhw_port.sv
module pcmhw_port
    import pcmhw_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 64,
    localparam int unsigned CW = $clog2(FRAME_BITS)
) (
    input  logic                pclk,
    input  logic                rst,
    input  logic                fsync,
    input  logic                drx,
    output logic                dtx,
    input  logic                cfg_fs_long,
    input  logic                cfg_lin16,
    input  logic                cfg_rel_late,
    input  logic [CW-1:0]       cfg_tx_start,
    input  logic [CW-1:0]       cfg_rx_start,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid,
    output logic                frame_tick,
    output logic                frame_err
);

    localparam int unsigned N_DIR = 2;   // 0 = transmit, 1 = receive

    hw_cfg_t       cfg;
    logic [CW-1:0] pos;
    logic          locked;
    logic          load;
    logic          tx_oe;
    logic          tx_bit;

    logic [CW-1:0] win_start [N_DIR];
    logic [CW-1:0] win_off   [N_DIR];
    logic          win_in    [N_DIR];
    logic          win_last  [N_DIR];

    assign cfg.fs_fmt = fs_fmt_e'(cfg_fs_long);
    assign cfg.width  = smp_width_e'(cfg_lin16);
    assign cfg.rel    = rel_edge_e'(cfg_rel_late);

    assign win_start[0] = cfg_tx_start;
    assign win_start[1] = cfg_rx_start;

    pcmhw_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
        .clk        (pclk),
        .rst        (rst),
        .fsync      (fsync),
        .fs_fmt     (cfg.fs_fmt),
        .pos        (pos),
        .locked     (locked),
        .load       (load),
        .frame_tick (frame_tick),
        .frame_err  (frame_err)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_win
        pcmhw_slot_win #(.CW(CW)) u_win (
            .pos     (pos),
            .start   (win_start[d]),
            .width   (cfg.width),
            .off     (win_off[d]),
            .in_slot (win_in[d]),
            .is_last (win_last[d])
        );
    end

    pcmhw_tx #(.CW(CW)) u_tx (
        .clk       (pclk),
        .rst       (rst),
        .load      (load),
        .tx_sample (tx_sample),
        .locked    (locked),
        .in_slot   (win_in[0]),
        .is_last   (win_last[0]),
        .off       (win_off[0]),
        .width     (cfg.width),
        .rel       (cfg.rel),
        .oe        (tx_oe),
        .bit_out   (tx_bit)
    );

    pcmhw_rx u_rx (
        .clk     (pclk),
        .rst     (rst),
        .drx     (drx),
        .locked  (locked),
        .in_slot (win_in[1]),
        .is_last (win_last[1]),
        .width   (cfg.width),
        .data    (rx_sample),
        .valid   (rx_valid)
    );

    assign dtx = tx_oe ? tx_bit : 1'bz;

    AST_FLOAT_UNLOCKED: assert property (@(posedge pclk) disable iff (rst)
        !locked |-> !tx_oe); // R9

    AST_OE_IN_WINDOW: assert property (@(posedge pclk) disable iff (rst)
        tx_oe |-> (win_off[0] < CW'(slot_len(cfg.width)))); // R3

    AST_RXV_PLACE: assert property (@(posedge pclk) disable iff (rst)
        (rx_valid && !frame_err) |-> (win_off[1] == CW'(slot_len(cfg.width)))); // R6

    AST_ERR_RELOAD: assert property (@(posedge pclk) disable iff (rst)
        frame_err |-> frame_tick); // R8

endmodule

// File: tb/test_pcmhw_port.sv
module test_pcmhw_port;

    localparam int CLK_PERIOD = 10;
    localparam int F          = 64;
    localparam int CW         = $clog2(F);

    typedef struct packed {
        logic          fl;
        logic          lin;
        logic          late;
        logic [CW-1:0] txs;
        logic [CW-1:0] rxs;
        logic [15:0]   txv;
        logic [15:0]   rxv;
    } vec_t;

    // R2 (sync shapes), R5 (release), R7 (independent starts)
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 6'd0,  6'd5,  16'h00A5, 16'h003C},
        '{1'b0, 1'b0, 1'b1, 6'd10, 6'd10, 16'h005A, 16'h00C3},
        '{1'b1, 1'b0, 1'b0, 6'd0,  6'd0,  16'h0096, 16'h0069},
        '{1'b1, 1'b1, 1'b1, 6'd20, 6'd40, 16'hBEEF, 16'h1234},
        '{1'b0, 1'b1, 1'b0, 6'd46, 6'd2,  16'hC3A5, 16'hF00F},
        '{1'b1, 1'b1, 1'b0, 6'd30, 6'd46, 16'h8001, 16'h7FFE}
    };

    logic          pclk = 1'b0;
    logic          rst = 1'b1;
    logic          fsync = 1'b0;
    logic          drx = 1'b0;
    logic          dtx;
    logic          cfg_fs_long = 1'b0;
    logic          cfg_lin16 = 1'b0;
    logic          cfg_rel_late = 1'b0;
    logic [CW-1:0] cfg_tx_start = '0;
    logic [CW-1:0] cfg_rx_start = '0;
    logic [15:0]   tx_sample = '0;
    logic [15:0]   rx_sample;
    logic          rx_valid;
    logic          frame_tick;
    logic          frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    pcmhw_port #(.FRAME_BITS(F)) i_pcmhw_port (
        .pclk         (pclk),
        .rst          (rst),
        .fsync        (fsync),
        .drx          (drx),
        .dtx          (dtx),
        .cfg_fs_long  (cfg_fs_long),
        .cfg_lin16    (cfg_lin16),
        .cfg_rel_late (cfg_rel_late),
        .cfg_tx_start (cfg_tx_start),
        .cfg_rx_start (cfg_rx_start),
        .tx_sample    (tx_sample),
        .rx_sample    (rx_sample),
        .rx_valid     (rx_valid),
        .frame_tick   (frame_tick),
        .frame_err    (frame_err)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_fs_long  = v.fl;
        cfg_lin16    = v.lin;
        cfg_rel_late = v.late;
        cfg_tx_start = v.txs;
        cfg_rx_start = v.rxs;
    endtask

    // Called just after a rising edge; leaves just after a rising edge.
    task automatic do_reset();
        rst = 1'b1;
        fsync = 1'b0;
        repeat (2) @(posedge pclk);
        #1;
        rst = 1'b0;
    endtask

    // One frame, from the period before bit 0 up to period len-2.
    task automatic do_frame(input vec_t v, input int len, input bit chk,
                            input bit exp_err, input int tick_at);
        int    tl;
        bit    ok_fl, ok_dt, ok_rel, ok_rx, ok_tk, ok_er;
        string a_fl, e_fl, a_dt, e_dt, a_rel, e_rel, a_rx, e_rx, a_tk, e_tk, a_er, e_er;
        logic  exp_b;
        logic  exp_b2;
        bit    in_tx;
        bit    in_rx;
        tl = v.lin ? 16 : 8;
        ok_fl = 1; ok_dt = 1; ok_rel = 1; ok_rx = 1; ok_tk = 1; ok_er = 1;
        for (int b = -1; b < len - 1; b++) begin
            fsync = v.fl ? (b == 0 || b == 1) : (b == -1);
            if (b == -1) tx_sample = v.txv;
            if (b == 1)  tx_sample = ~v.txv;
            in_tx = (b >= int'(v.txs)) && (b < int'(v.txs) + tl);
            in_rx = (b >= int'(v.rxs)) && (b < int'(v.rxs) + tl);
            drx = in_rx ? v.rxv[tl - 1 - (b - int'(v.rxs))] : b[0];
            exp_b = in_tx ? v.txv[tl - 1 - (b - int'(v.txs))] : 1'bz;
            #1;
            // first half of the bit period
            if (dtx !== exp_b) begin
                if (exp_b === 1'bz) begin
                    if (ok_fl) begin a_fl = $sformatf("%b@%0d", dtx, b); e_fl = "z"; end
                    ok_fl = 0;
                end else begin
                    if (ok_dt) begin a_dt = $sformatf("%b@%0d", dtx, b); e_dt = $sformatf("%b", exp_b); end
                    ok_dt = 0;
                end
            end
            if (rx_valid !== (b == int'(v.rxs) + tl)) begin
                if (ok_rx) begin a_rx = $sformatf("valid=%b@%0d", rx_valid, b); e_rx = $sformatf("valid at %0d", int'(v.rxs) + tl); end
                ok_rx = 0;
            end else if (rx_valid && rx_sample !== (v.lin ? v.rxv : {8'h00, v.rxv[7:0]})) begin
                if (ok_rx) begin a_rx = $sformatf("%h", rx_sample); e_rx = $sformatf("%h", v.lin ? v.rxv : {8'h00, v.rxv[7:0]}); end
                ok_rx = 0;
            end
            if (frame_tick !== (b == tick_at)) begin
                if (ok_tk) begin a_tk = $sformatf("%b@%0d", frame_tick, b); e_tk = $sformatf("pulse at %0d", tick_at); end
                ok_tk = 0;
            end
            if (frame_err !== (exp_err && b == (v.fl ? 1 : 0))) begin
                if (ok_er) begin a_er = $sformatf("%b@%0d", frame_err, b); e_er = exp_err ? "pulse" : "0"; end
                ok_er = 0;
            end
            @(negedge pclk);
            #2;
            // second half of the bit period
            exp_b2 = (in_tx && b == int'(v.txs) + tl - 1 && !v.late) ? 1'bz : exp_b;
            if (dtx !== exp_b2) begin
                if (ok_rel) begin a_rel = $sformatf("%b@%0d", dtx, b); e_rel = $sformatf("%b", exp_b2); end
                ok_rel = 0;
            end
            @(posedge pclk);
            #1;
        end
        if (chk) begin
            check(ok_fl,  "R3 dtx float outside slot", a_fl, e_fl);
            check(ok_dt,  "R4 dtx bit order", a_dt, e_dt);
            check(ok_rel, "R5 dtx release edge", a_rel, e_rel);
            check(ok_rx,  "R6 rx sample and strobe", a_rx, e_rx);
            check(ok_tk,  "R10 frame tick", a_tk, e_tk);
            check(ok_er,  "R8 frame error", a_er, e_er);
        end
    endtask

    task automatic final_report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            final_report();
        end
    end

    initial begin
        bit ok;
        @(posedge pclk);
        #1;
        // R1: reset state
        apply_cfg(VECS[0]);
        rst = 1'b1;
        repeat (2) @(posedge pclk);
        #2;
        check((dtx === 1'bz) && !rx_valid && !frame_tick && !frame_err, "R1 reset state",
              $sformatf("dtx=%b v=%b t=%b e=%b", dtx, rx_valid, frame_tick, frame_err), "z 0 0 0");
        @(posedge pclk);
        #1;
        rst = 1'b0;

        // R9: no sync yet, slot at position 0 must stay silent
        ok = 1;
        for (int c = 0; c < 2 * F; c++) begin
            drx = c[0];
            #1;
            if (dtx !== 1'bz || rx_valid || frame_tick || frame_err) ok = 0;
            @(posedge pclk);
            #1;
        end
        check(ok, "R9 silent before first sync", ok ? "silent" : "activity", "silent");

        // table walk: each vector gets a lock frame then a checked frame
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VECS[i]);
            do_reset();
            do_frame(VECS[i], F, 1'b0, 1'b0, VECS[i].fl ? 1 : 0);
            do_frame(VECS[i], F, 1'b1, 1'b0, 0);
        end

        // R8: early short sync realigns the frame
        apply_cfg(VECS[0]);
        do_reset();
        do_frame(VECS[0], F, 1'b0, 1'b0, 0);
        do_frame(VECS[0], 30, 1'b1, 1'b0, 0);
        do_frame(VECS[0], F, 1'b1, 1'b1, 0);
        do_frame(VECS[0], F, 1'b1, 1'b0, 0);

        // R8: early long sync realigns, reload lands in bit 1
        apply_cfg(VECS[3]);
        do_reset();
        do_frame(VECS[3], F, 1'b0, 1'b0, 1);
        do_frame(VECS[3], 60, 1'b1, 1'b0, 0);
        do_frame(VECS[3], F, 1'b1, 1'b1, 1);

        done = 1;
        final_report();
    end

endmodule